// File: doc/BRIEF.md
# Combined Floating-Point Operation Decoder

This block decodes a two-step fused floating-point instruction that computes `(s1 op1 s2) op2 s3`. An issue slot presents a major opcode, a 6-bit minor opcode, the execution channel the instruction was steered to and the architecture version of the core. When the major opcode belongs to one of the two combined-operation classes, the decoder works out the precision, the operation of each stage and whether the second stage takes its operands in reversed order. It then checks the pair of operations against the rules for version and channel.

One clock after a qualified input, the decoder presents its result. A legal instruction raises a one-cycle result-valid with the control fields and a merged operand tag for the arithmetic units. An illegal one raises a one-cycle illegal-opcode strobe instead and produces no result. Major opcodes outside the two classes are left alone for other decoders and produce neither signal. The arithmetic itself lies outside this block.

Top module: `fcomb_decoder`

## Requirements
- R1: On a result, `res_dbl` equals bit 0 of the minor opcode (1 = 64-bit double, 0 = 32-bit single).
- R2: Minor bits 4:1 choose the first stage: 0 is add (`res_op1`=0), 1 is subtract (`res_op1`=1), 4 is multiply (`res_op1`=2). Any other value raises the illegal strobe.
- R3: A first-stage add or subtract is legal only when the version is 4 or higher, or when the version is at least 2 and the channel is 0, 1, 3 or 4. Otherwise it is illegal.
- R4: A first-stage multiply is legal on channels 0, 1, 3 and 4 at every version, and on any channel when the version is 4 or higher. Otherwise it is illegal.
- R5: For the first class (major 0x50), minor bit 5 clear gives a second-stage add (`res_op2`=0) and minor bit 5 set gives a second-stage subtract, intermediate minus s3 (`res_op2`=1, `res_swap`=0).
- R6: For the second class (major 0x51), minor bit 5 set gives a reversed subtract, s3 minus intermediate (`res_op2`=1, `res_swap`=1). Minor bit 5 clear gives a second-stage multiply (`res_op2`=2), and only when the version equals 1. At any other version it is illegal.
- R7: On a result, `res_tag` is the bitwise OR of the three 2-bit source tags.
- R8: Outputs register one cycle after the input. `res_valid` and `res_illegal` are single-cycle pulses and never both high. On an illegal decode all control fields and the tag read 0.
- R9: With `dec_valid` low, or with a major opcode other than 0x50 or 0x51, neither `res_valid` nor `res_illegal` rises and all fields read 0 in the next cycle.
- R10: After a synchronous reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | Input fields are qualified this cycle |
| major_op | input | 7 | Major opcode; 0x50 and 0x51 are the combined classes |
| minor_op | input | 6 | Minor opcode: bit 5 second-stage group, bits 4:1 first stage, bit 0 precision |
| chan | input | 3 | Execution channel number |
| arch_ver | input | 4 | Architecture version |
| tag_s1 | input | 2 | Tag of source 1 |
| tag_s2 | input | 2 | Tag of source 2 |
| tag_s3 | input | 2 | Tag of source 3 |
| res_valid | output | 1 | Legal combined instruction decoded |
| res_illegal | output | 1 | Illegal-opcode exception strobe |
| res_dbl | output | 1 | Double precision select |
| res_op1 | output | 2 | First-stage operation: 0 add, 1 sub, 2 mul |
| res_op2 | output | 2 | Second-stage operation: 0 add, 1 sub, 2 mul |
| res_swap | output | 1 | Second stage computes s3 minus intermediate |
| res_tag | output | 2 | Merged result tag |

## Verification
On every cycle, the assertions check the following: the result and illegal strobes never overlap; an unqualified or foreign opcode leaves both low; the precision bit and the merged tag follow the input of the previous cycle; and the specific illegal combinations of channel and version fire the strobe. The exact decode across the full space of version and channel, the second-class multiply that exists only on version 1, and the reversed-subtract encoding are shown by the bench's directed and random scenarios, which are compared against an independent model.

// File: rtl/fcomb_pkg.sv
package fcomb_pkg;

  typedef enum logic [1:0] {
    FOP_ADD  = 2'd0,
    FOP_SUB  = 2'd1,
    FOP_MUL  = 2'd2,
    FOP_NONE = 2'd3
  } fop_e;

  localparam logic [3:0] S1_CODE_ADD = 4'd0;
  localparam logic [3:0] S1_CODE_SUB = 4'd1;
  localparam logic [3:0] S1_CODE_MUL = 4'd4;

endpackage

// File: rtl/fcomb_stage1_dec.sv
module fcomb_stage1_dec
  import fcomb_pkg::*;
#(
  parameter int CH_W = 3,
  parameter int VER_W = 4,
  parameter logic [(2**CH_W)-1:0] FAST_CH_MASK = 8'b0001_1011,
  parameter logic [VER_W-1:0] VER_ADDSUB = VER_W'(2),
  parameter logic [VER_W-1:0] VER_ALLCH = VER_W'(4)
) (
  input  logic [3:0]       code,
  input  logic [CH_W-1:0]  chan,
  input  logic [VER_W-1:0] ver,
  output fop_e             op1,
  output logic             legal1
);
  logic fast_ch;
  logic any_ch;
  logic addsub_ok;
  logic mul_ok;

  assign fast_ch   = FAST_CH_MASK[chan];
  assign any_ch    = (ver >= VER_ALLCH);
  assign addsub_ok = ((ver >= VER_ADDSUB) && fast_ch) || any_ch;
  assign mul_ok    = fast_ch || any_ch;

  always_comb begin
    op1    = FOP_NONE;
    legal1 = 1'b0;
    unique case (code)
      S1_CODE_ADD: begin
        op1    = FOP_ADD;
        legal1 = addsub_ok;
      end
      S1_CODE_SUB: begin
        op1    = FOP_SUB;
        legal1 = addsub_ok;
      end
      S1_CODE_MUL: begin
        op1    = FOP_MUL;
        legal1 = mul_ok;
      end
      default: begin
        op1    = FOP_NONE;
        legal1 = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/fcomb_stage2_dec.sv
module fcomb_stage2_dec
  import fcomb_pkg::*;
#(
  parameter int VER_W = 4,
  parameter logic [VER_W-1:0] VER_MUL2 = VER_W'(1)
) (
  input  logic             cls_b,
  input  logic             grp,
  input  logic [VER_W-1:0] ver,
  output fop_e             op2,
  output logic             swap,
  output logic             legal2
);
  always_comb begin
    op2    = FOP_NONE;
    swap   = 1'b0;
    legal2 = 1'b0;
    if (!grp) begin
      if (!cls_b) begin
        op2    = FOP_ADD;
        legal2 = 1'b1;
      end else begin
        op2    = FOP_MUL;
        legal2 = (ver == VER_MUL2);
      end
    end else begin
      op2    = FOP_SUB;
      swap   = cls_b;
      legal2 = 1'b1;
    end
  end
endmodule

// File: rtl/fcomb_tag_merge.sv
module fcomb_tag_merge #(
  parameter int TAG_W = 2,
  parameter int NSRC = 3
) (
  input  logic [NSRC-1:0][TAG_W-1:0] tags,
  output logic [TAG_W-1:0]           merged
);
  logic [NSRC:0][TAG_W-1:0] acc;
  assign acc[0] = '0;
  for (genvar i = 0; i < NSRC; i++) begin : g_or
    assign acc[i+1] = acc[i] | tags[i];
  end
  assign merged = acc[NSRC];
endmodule

// File: rtl/fcomb_out_reg.sv
module fcomb_out_reg #(
  parameter int TAG_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit,
  input  logic             legal,
  input  logic             dbl_d,
  input  logic [1:0]       op1_d,
  input  logic [1:0]       op2_d,
  input  logic             swap_d,
  input  logic [TAG_W-1:0] tag_d,
  output logic             valid_q,
  output logic             illegal_q,
  output logic             dbl_q,
  output logic [1:0]       op1_q,
  output logic [1:0]       op2_q,
  output logic             swap_q,
  output logic [TAG_W-1:0] tag_q
);
  logic take;
  assign take = hit && legal;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q   <= 1'b0;
      illegal_q <= 1'b0;
      dbl_q     <= 1'b0;
      op1_q     <= '0;
      op2_q     <= '0;
      swap_q    <= 1'b0;
      tag_q     <= '0;
    end else begin
      valid_q   <= take;
      illegal_q <= hit && !legal;
      dbl_q     <= take ? dbl_d  : 1'b0;
      op1_q     <= take ? op1_d  : 2'd0;
      op2_q     <= take ? op2_d  : 2'd0;
      swap_q    <= take ? swap_d : 1'b0;
      tag_q     <= take ? tag_d  : '0;
    end
  end
endmodule

// File: rtl/fcomb_decoder.sv
module fcomb_decoder
  import fcomb_pkg::*;
#(
  parameter int MAJ_W = 7,
  parameter int CH_W = 3,
  parameter int VER_W = 4,
  parameter int TAG_W = 2,
  parameter logic [MAJ_W-1:0] CLS_A = MAJ_W'(7'h50),
  parameter logic [MAJ_W-1:0] CLS_B = MAJ_W'(7'h51),
  parameter logic [(2**CH_W)-1:0] FAST_CH_MASK = 8'b0001_1011
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dec_valid,
  input  logic [MAJ_W-1:0] major_op,
  input  logic [5:0]       minor_op,
  input  logic [CH_W-1:0]  chan,
  input  logic [VER_W-1:0] arch_ver,
  input  logic [TAG_W-1:0] tag_s1,
  input  logic [TAG_W-1:0] tag_s2,
  input  logic [TAG_W-1:0] tag_s3,
  output logic             res_valid,
  output logic             res_illegal,
  output logic             res_dbl,
  output logic [1:0]       res_op1,
  output logic [1:0]       res_op2,
  output logic             res_swap,
  output logic [TAG_W-1:0] res_tag
);
  localparam int NSRC = 3;

  logic is_a, is_b, hit;
  fop_e op1, op2;
  logic legal1, legal2, swap;
  logic [TAG_W-1:0] merged;
  logic [NSRC-1:0][TAG_W-1:0] tag_vec;

  assign is_a = (major_op == CLS_A);
  assign is_b = (major_op == CLS_B);
  assign hit  = dec_valid && (is_a || is_b);
  assign tag_vec = {tag_s3, tag_s2, tag_s1};

  fcomb_stage1_dec #(
    .CH_W(CH_W), .VER_W(VER_W), .FAST_CH_MASK(FAST_CH_MASK)
  ) u_s1 (
    .code(minor_op[4:1]), .chan(chan), .ver(arch_ver),
    .op1(op1), .legal1(legal1)
  );

  fcomb_stage2_dec #(.VER_W(VER_W)) u_s2 (
    .cls_b(is_b), .grp(minor_op[5]), .ver(arch_ver),
    .op2(op2), .swap(swap), .legal2(legal2)
  );

  fcomb_tag_merge #(.TAG_W(TAG_W), .NSRC(NSRC)) u_tag (
    .tags(tag_vec), .merged(merged)
  );

  fcomb_out_reg #(.TAG_W(TAG_W)) u_out (
    .clk(clk), .rst(rst), .hit(hit), .legal(legal1 && legal2),
    .dbl_d(minor_op[0]), .op1_d(op1), .op2_d(op2), .swap_d(swap),
    .tag_d(merged),
    .valid_q(res_valid), .illegal_q(res_illegal), .dbl_q(res_dbl),
    .op1_q(res_op1), .op2_q(res_op2), .swap_q(res_swap), .tag_q(res_tag)
  );
endmodule

// File: rtl/fcomb_decoder_chk.sv
module fcomb_decoder_chk #(
  parameter int MAJ_W = 7,
  parameter int CH_W = 3,
  parameter int VER_W = 4,
  parameter int TAG_W = 2,
  parameter logic [MAJ_W-1:0] CLS_A = MAJ_W'(7'h50),
  parameter logic [MAJ_W-1:0] CLS_B = MAJ_W'(7'h51),
  parameter logic [(2**CH_W)-1:0] FAST_CH_MASK = 8'b0001_1011
) (
  input logic             clk,
  input logic             rst,
  input logic             dec_valid,
  input logic [MAJ_W-1:0] major_op,
  input logic [5:0]       minor_op,
  input logic [CH_W-1:0]  chan,
  input logic [VER_W-1:0] arch_ver,
  input logic [TAG_W-1:0] tag_s1,
  input logic [TAG_W-1:0] tag_s2,
  input logic [TAG_W-1:0] tag_s3,
  input logic             res_valid,
  input logic             res_illegal,
  input logic             res_dbl,
  input logic [1:0]       res_op1,
  input logic [1:0]       res_op2,
  input logic             res_swap,
  input logic [TAG_W-1:0] res_tag
);
  logic cls;
  assign cls = (major_op == CLS_A) || (major_op == CLS_B);

  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(res_valid && res_illegal)); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!dec_valid || !cls) |=> (!res_valid && !res_illegal)); // R9

  AST_PREC_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && cls) |=> (!res_valid || (res_dbl == $past(minor_op[0])))); // R1

  AST_TAG_OR: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && cls) |=> (!res_valid || (res_tag == $past(tag_s1 | tag_s2 | tag_s3)))); // R7

  AST_BAD_STAGE1: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && cls && (minor_op[4:1] != 4'd0) && (minor_op[4:1] != 4'd1)
     && (minor_op[4:1] != 4'd4)) |=> res_illegal); // R2

  AST_ADDSUB_OLD: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && cls && (minor_op[4:2] == 3'd0) && (arch_ver < VER_W'(2)))
    |=> res_illegal); // R3

  AST_MUL_SLOWCH: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && cls && (minor_op[4:1] == 4'd4) && !FAST_CH_MASK[chan]
     && (arch_ver < VER_W'(4))) |=> res_illegal); // R4

  AST_MUL2_VER: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && (major_op == CLS_B) && !minor_op[5] && (arch_ver != VER_W'(1)))
    |=> res_illegal); // R6

  AST_SWAP_SUB: assert property (@(posedge clk) disable iff (rst)
    res_swap |-> (res_valid && (res_op2 == 2'd1))); // R6

  AST_FIELDS_IDLE: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> (res_op1 == 2'd0 && res_op2 == 2'd0 && !res_swap && !res_dbl)); // R8
endmodule

bind fcomb_decoder fcomb_decoder_chk #(
  .MAJ_W(MAJ_W), .CH_W(CH_W), .VER_W(VER_W), .TAG_W(TAG_W),
  .CLS_A(CLS_A), .CLS_B(CLS_B), .FAST_CH_MASK(FAST_CH_MASK)
) u_chk (
  .clk(clk), .rst(rst), .dec_valid(dec_valid), .major_op(major_op),
  .minor_op(minor_op), .chan(chan), .arch_ver(arch_ver),
  .tag_s1(tag_s1), .tag_s2(tag_s2), .tag_s3(tag_s3),
  .res_valid(res_valid), .res_illegal(res_illegal), .res_dbl(res_dbl),
  .res_op1(res_op1), .res_op2(res_op2), .res_swap(res_swap), .res_tag(res_tag)
);

// File: tb/fcomb_decoder_bench.sv
module fcomb_decoder_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dec_valid = 1'b0;
  logic [6:0] major_op = '0;
  logic [5:0] minor_op = '0;
  logic [2:0] chan = '0;
  logic [3:0] arch_ver = '0;
  logic [1:0] tag_s1 = '0, tag_s2 = '0, tag_s3 = '0;
  logic       res_valid, res_illegal, res_dbl, res_swap;
  logic [1:0] res_op1, res_op2, res_tag;

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  fcomb_decoder u_fcomb_decoder (
    .clk(clk), .rst(rst), .dec_valid(dec_valid), .major_op(major_op),
    .minor_op(minor_op), .chan(chan), .arch_ver(arch_ver),
    .tag_s1(tag_s1), .tag_s2(tag_s2), .tag_s3(tag_s3),
    .res_valid(res_valid), .res_illegal(res_illegal), .res_dbl(res_dbl),
    .res_op1(res_op1), .res_op2(res_op2), .res_swap(res_swap), .res_tag(res_tag)
  );

  // Expected {valid, illegal, dbl, op1[1:0], op2[1:0], swap, tag[1:0]}
  function automatic logic [9:0] model(logic iv, logic [6:0] maj, logic [5:0] mn,
                                       logic [2:0] ch, logic [3:0] v,
                                       logic [1:0] a, logic [1:0] b, logic [1:0] c);
    logic fast, l1, l2, sw;
    logic [1:0] o1, o2;
    fast = (ch == 3'd0) || (ch == 3'd1) || (ch == 3'd3) || (ch == 3'd4);
    if (!iv || (maj != 7'h50 && maj != 7'h51)) return 10'd0;
    l1 = 1'b0; o1 = 2'd0;
    if (mn[4:1] == 4'd0)      begin o1 = 2'd0; l1 = (v >= 4'd2 && fast) || v >= 4'd4; end
    else if (mn[4:1] == 4'd1) begin o1 = 2'd1; l1 = (v >= 4'd2 && fast) || v >= 4'd4; end
    else if (mn[4:1] == 4'd4) begin o1 = 2'd2; l1 = fast || v >= 4'd4; end
    sw = 1'b0;
    if (!mn[5]) begin
      if (maj == 7'h50) begin o2 = 2'd0; l2 = 1'b1; end
      else              begin o2 = 2'd2; l2 = (v == 4'd1); end
    end else begin
      o2 = 2'd1; l2 = 1'b1; sw = (maj == 7'h51);
    end
    if (l1 && l2) return {1'b1, 1'b0, mn[0], o1, o2, sw, a | b | c};
    return {1'b0, 1'b1, 8'd0};
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic apply(logic iv, logic [6:0] maj, logic [5:0] mn, logic [2:0] ch,
                       logic [3:0] v, logic [1:0] a, logic [1:0] b, logic [1:0] c,
                       string req);
    logic [9:0] e;
    dec_valid = iv; major_op = maj; minor_op = mn; chan = ch; arch_ver = v;
    tag_s1 = a; tag_s2 = b; tag_s3 = c;
    e = model(iv, maj, mn, ch, v, a, b, c);
    @(negedge clk);
    chk(req, "valid", res_valid, e[9]);
    chk(req, "illegal", res_illegal, e[8]);
    chk("R1", "dbl", res_dbl, e[7]);
    chk("R2", "op1", res_op1, e[6:5]);
    chk("R5/R6", "op2", res_op2, e[4:3]);
    chk("R6", "swap", res_swap, e[2]);
    chk("R7", "tag", res_tag, e[1:0]);
  endtask

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk("R10", "valid", res_valid, 0);
    chk("R10", "illegal", res_illegal, 0);
    chk("R10", "fields", {res_dbl, res_op1, res_op2, res_swap, res_tag}, 0);
    // Directed corners
    apply(1, 7'h50, 6'b000000, 3'd0, 4'd2, 2'd0, 2'd0, 2'd0, "R3");  // add fast v2 legal
    apply(1, 7'h50, 6'b000010, 3'd2, 4'd3, 2'd0, 2'd0, 2'd0, "R3");  // sub slow v3 illegal
    apply(0, 7'h50, 6'b000000, 3'd0, 4'd2, 2'd0, 2'd0, 2'd0, "R8");  // strobe drops
    apply(1, 7'h50, 6'b000011, 3'd2, 4'd4, 2'd1, 2'd0, 2'd0, "R3");  // sub any ch v4
    apply(1, 7'h50, 6'b000000, 3'd1, 4'd1, 2'd0, 2'd0, 2'd0, "R3");  // add v1 illegal
    apply(1, 7'h50, 6'b001000, 3'd2, 4'd1, 2'd0, 2'd0, 2'd0, "R4");  // mul slow illegal
    apply(1, 7'h50, 6'b001001, 3'd0, 4'd0, 2'd0, 2'd2, 2'd0, "R4");  // mul fast v0
    apply(1, 7'h50, 6'b001000, 3'd7, 4'd4, 2'd0, 2'd0, 2'd0, "R4");  // mul any ch v4
    apply(1, 7'h50, 6'b000110, 3'd0, 4'd5, 2'd0, 2'd0, 2'd0, "R2");  // code 3 illegal
    apply(1, 7'h50, 6'b100001, 3'd3, 4'd2, 2'd0, 2'd0, 2'd1, "R5");  // sub second stage
    apply(1, 7'h51, 6'b001000, 3'd4, 4'd1, 2'd0, 2'd0, 2'd0, "R6");  // mul2 v1 legal
    apply(1, 7'h51, 6'b001000, 3'd4, 4'd2, 2'd0, 2'd0, 2'd0, "R6");  // mul2 v2 illegal
    apply(1, 7'h51, 6'b100010, 3'd1, 4'd3, 2'd1, 2'd2, 2'd0, "R6");  // reversed sub
    apply(1, 7'h52, 6'b000000, 3'd0, 4'd4, 2'd3, 2'd3, 2'd3, "R9");  // foreign major
    apply(0, 7'h51, 6'b100000, 3'd0, 4'd4, 2'd3, 2'd3, 2'd3, "R9");  // not qualified
    apply(1, 7'h50, 6'b000001, 3'd0, 4'd7, 2'd1, 2'd2, 2'd0, "R7");  // tag merge, dbl
    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic [6:0] mj;
      logic [5:0] mn;
      int r;
      r = $urandom_range(0, 9);
      mj = (r < 4) ? 7'h50 : (r < 8) ? 7'h51 : 7'($urandom);
      mn = 6'($urandom);
      if ($urandom_range(0, 3) != 0) begin
        r = $urandom_range(0, 2);
        mn[4:1] = (r == 0) ? 4'd0 : (r == 1) ? 4'd1 : 4'd4;
      end
      apply(($urandom_range(0, 7) != 0), mj, mn, 3'($urandom), 4'($urandom_range(0, 7)),
            2'($urandom), 2'($urandom), 2'($urandom), "R2/R3/R4/R6/R8/R9");
    end
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule